// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block accepts one digitized pixel word per pixel clock along with horizontal sync, vertical sync and a sync-on-green flag. It distributes the pixels over two output ports, A and B. In single-port mode every pixel leaves on port A and port B is released. In dual-port mode consecutive pixels are split between the ports, either one at a time (interleaved) or as a pair that appears on both ports together on every second sample (pair mode).

The odd/even count of the pixels restarts on each horizontal sync leading edge, so the pixel-to-port mapping is the same on every line. A swap control decides which port receives the first pixel of a line. The three mode controls are captured only on a leading edge, so a line never changes mode partway through. The sync outputs have selectable polarity and are delayed to stay aligned with the port data. A strobe marks each output data clock.

Top module: `pix_demux_top`

## Requirements
- R1: While reset is held, every output is 0. After reset and before the first horizontal sync leading edge, the captured demux, pair and swap controls behave as if all three were 1, whatever their inputs are.
- R2: In single-port mode (demux 0), each pixel appears on `port_a` one clock after it is sampled. `oe_a`=1, `oe_b`=0, `port_b`=0, and `dclk_en` pulses every clock. Pair and swap have no effect.
- R3: In interleaved dual-port mode (demux 1, pair 0), each pixel goes to one port one clock later and the other port holds its value. `oe_a`=`oe_b`=1 and `dclk_en`=1 every clock.
- R4: In pair mode (demux 1, pair 1), an odd sample is held and no output changes (`dclk_en`=0). On the following even sample both ports update together and `dclk_en`=1.
- R5: With swap 0, odd samples (the first sample of a line is sample 1) go to port A and even samples go to port B. With swap 1 the assignment is reversed.
- R6: The sample taken on the clock where `hs_in` is first seen high after being low counts as odd. In pair mode, an unpaired odd sample left at the end of a line is dropped.
- R7: A change on `cfg_demux`, `cfg_pair` or `cfg_swap` takes effect only with the sample at the next horizontal sync leading edge.
- R8: `hs_out` and `sog_out` equal `hs_in` and `sog_in` of the previous clock XOR `cfg_hs_neg` of that clock. A value of 1 gives active-low output.
- R9: `vs_out` equals `vs_in` of the previous clock XOR `cfg_vs_inv` of that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_in | input | PIX_W | Pixel sample, one per clock |
| hs_in | input | 1 | Horizontal sync, active high |
| vs_in | input | 1 | Vertical sync, active high |
| sog_in | input | 1 | Sync-on-green indication |
| cfg_demux | input | 1 | 1 = dual-port, 0 = single-port |
| cfg_pair | input | 1 | 1 = pair mode, 0 = interleaved |
| cfg_swap | input | 1 | 1 = first pixel of line goes to port B |
| cfg_hs_neg | input | 1 | 1 = active-low hs_out/sog_out |
| cfg_vs_inv | input | 1 | 1 = invert vs_out |
| port_a | output | PIX_W | Port A data |
| port_b | output | PIX_W | Port B data |
| oe_a | output | 1 | Port A output enable |
| oe_b | output | 1 | Port B output enable (0 = high impedance) |
| dclk_en | output | 1 | Output data clock strobe |
| hs_out | output | 1 | Horizontal sync out, aligned to data |
| vs_out | output | 1 | Vertical sync out, aligned to data |
| sog_out | output | 1 | Sync-on-green out, aligned to data |

## Verification
The bench runs lines of odd length in pair mode. A design that failed to drop the leftover sample would pair it with the first pixel of the next line and shift every following pair by one. It changes the mode controls in the middle of a line; a design that applied them at once would switch ports or strobe rate partway along the line. It also leaves the controls at 0 after reset before any sync edge, which shows whether the captured defaults are 1 rather than copied from the inputs, and it swaps the ports to catch a reversed parity.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;

  typedef struct packed {
    logic demux;
    logic pair;
    logic swap;
  } mode_t;

  localparam mode_t MODE_RST = '{demux: 1'b1, pair: 1'b1, swap: 1'b1};

  // Sample goes to port A when its parity matches the unswapped mapping.
  function automatic logic goes_to_a(input logic odd, input logic swap);
    return odd ^ swap;
  endfunction

  function automatic logic sync_level(input logic sig, input logic inv);
    return sig ^ inv;
  endfunction

endpackage

// File: rtl/pix_line_ctl.sv
module pix_line_ctl
  import pix_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hs_in,
  input  mode_t cfg_in,
  output logic  hs_lead,
  output logic  smp_odd,
  output mode_t eff,
  output mode_t act
);

  logic hs_q;
  logic odd_nxt;

  assign hs_lead = hs_in & ~hs_q;
  assign smp_odd = hs_lead | odd_nxt;
  assign eff     = hs_lead ? cfg_in : act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      odd_nxt <= 1'b1;
      act     <= MODE_RST;
    end else begin
      hs_q    <= hs_in;
      odd_nxt <= ~smp_odd;
      if (hs_lead) act <= cfg_in;
    end
  end

endmodule

// File: rtl/pix_port_route.sv
module pix_port_route
  import pix_demux_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix,
  input  logic             smp_odd,
  input  mode_t            eff,
  output logic [PIX_W-1:0] port_a,
  output logic [PIX_W-1:0] port_b,
  output logic             oe_a,
  output logic             oe_b,
  output logic             dclk_en
);

  logic [PIX_W-1:0] hold;
  logic             to_a;

  assign to_a = goes_to_a(smp_odd, eff.swap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_a  <= '0;
      port_b  <= '0;
      oe_a    <= 1'b0;
      oe_b    <= 1'b0;
      dclk_en <= 1'b0;
      hold    <= '0;
    end else begin
      oe_a <= 1'b1;
      oe_b <= eff.demux;
      if (!eff.demux) begin
        port_a  <= pix;
        port_b  <= '0;
        dclk_en <= 1'b1;
      end else if (!eff.pair) begin
        if (to_a) port_a <= pix;
        else      port_b <= pix;
        dclk_en <= 1'b1;
      end else if (smp_odd) begin
        hold    <= pix;
        dclk_en <= 1'b0;
      end else begin
        if (eff.swap) begin
          port_a <= pix;
          port_b <= hold;
        end else begin
          port_a <= hold;
          port_b <= pix;
        end
        dclk_en <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pix_sync_out.sv
module pix_sync_out
  import pix_demux_pkg::*;
#(
  parameter int N_SYNC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SYNC-1:0] sync_in,
  input  logic [N_SYNC-1:0] inv,
  output logic [N_SYNC-1:0] sync_out
);

  for (genvar i = 0; i < N_SYNC; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_out[i] <= 1'b0;
      else        sync_out[i] <= sync_level(sync_in[i], inv[i]);
    end
  end

endmodule

// File: rtl/pix_demux_top.sv
module pix_demux_top
  import pix_demux_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             sog_in,
  input  logic             cfg_demux,
  input  logic             cfg_pair,
  input  logic             cfg_swap,
  input  logic             cfg_hs_neg,
  input  logic             cfg_vs_inv,
  output logic [PIX_W-1:0] port_a,
  output logic [PIX_W-1:0] port_b,
  output logic             oe_a,
  output logic             oe_b,
  output logic             dclk_en,
  output logic             hs_out,
  output logic             vs_out,
  output logic             sog_out
);

  localparam int N_SYNC = 3;

  mode_t             cfg_in;
  mode_t             eff;
  mode_t             act;
  logic              hs_lead;
  logic              smp_odd;
  logic [N_SYNC-1:0] sync_raw;
  logic [N_SYNC-1:0] sync_inv;
  logic [N_SYNC-1:0] sync_del;

  assign cfg_in = '{demux: cfg_demux, pair: cfg_pair, swap: cfg_swap};

  pix_line_ctl u_line (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .cfg_in(cfg_in),
    .hs_lead(hs_lead), .smp_odd(smp_odd), .eff(eff), .act(act)
  );

  pix_port_route #(.PIX_W(PIX_W)) u_route (
    .clk(clk), .rst_n(rst_n), .pix(pix_in), .smp_odd(smp_odd), .eff(eff),
    .port_a(port_a), .port_b(port_b), .oe_a(oe_a), .oe_b(oe_b),
    .dclk_en(dclk_en)
  );

  assign sync_raw = {vs_in, sog_in, hs_in};
  assign sync_inv = {cfg_vs_inv, cfg_hs_neg, cfg_hs_neg};

  pix_sync_out #(.N_SYNC(N_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_raw), .inv(sync_inv),
    .sync_out(sync_del)
  );

  assign hs_out  = sync_del[0];
  assign sog_out = sync_del[1];
  assign vs_out  = sync_del[2];

endmodule

// File: rtl/pix_demux_chk.sv
module pix_demux_chk
  import pix_demux_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] pix_in,
  input logic             hs_in,
  input logic             vs_in,
  input logic             sog_in,
  input logic             cfg_hs_neg,
  input logic             cfg_vs_inv,
  input logic [PIX_W-1:0] port_a,
  input logic [PIX_W-1:0] port_b,
  input logic             oe_b,
  input logic             dclk_en,
  input logic             hs_out,
  input logic             vs_out,
  input logic             sog_out,
  input logic             hs_lead,
  input logic             smp_odd,
  input mode_t            eff,
  input mode_t            act
);

  AST_SINGLE_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    !eff.demux |=> (port_a == $past(pix_in)) && !oe_b && dclk_en); // R2

  AST_INTERLEAVE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (eff.demux && !eff.pair && goes_to_a(smp_odd, eff.swap))
      |=> (port_a == $past(pix_in)) && $stable(port_b)); // R3

  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eff.demux && eff.pair && !smp_odd) |=> dclk_en && oe_b); // R4

  AST_PAIR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (eff.demux && eff.pair && smp_odd)
      |=> !dclk_en && $stable(port_a) && $stable(port_b)); // R4

  AST_SWAP_ODD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (eff.demux && !eff.pair && smp_odd && eff.swap)
      |=> port_b == $past(pix_in)); // R5

  AST_ANCHOR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_in && !$past(hs_in)) |-> smp_odd); // R6

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_lead |=> $stable(act)); // R7

  AST_HS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (hs_out == ($past(hs_in) ^ $past(cfg_hs_neg)))
           && (sog_out == ($past(sog_in) ^ $past(cfg_hs_neg)))); // R8

  AST_VS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> vs_out == ($past(vs_in) ^ $past(cfg_vs_inv))); // R9

endmodule

bind pix_demux_top pix_demux_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in),
  .sog_in(sog_in), .cfg_hs_neg(cfg_hs_neg), .cfg_vs_inv(cfg_vs_inv),
  .port_a(port_a), .port_b(port_b), .oe_b(oe_b), .dclk_en(dclk_en),
  .hs_out(hs_out), .vs_out(vs_out), .sog_out(sog_out),
  .hs_lead(hs_lead), .smp_odd(smp_odd), .eff(eff), .act(act)
);

// File: tb/sim_pix_demux_top.sv
module sim_pix_demux_top;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pix_in = '0;
  logic         hs_in = 1'b0, vs_in = 1'b0, sog_in = 1'b0;
  logic         cfg_demux = 1'b0, cfg_pair = 1'b0, cfg_swap = 1'b0;
  logic         cfg_hs_neg = 1'b0, cfg_vs_inv = 1'b0;
  logic [W-1:0] port_a, port_b;
  logic         oe_a, oe_b, dclk_en, hs_out, vs_out, sog_out;

  always #2 clk = ~clk;

  pix_demux_top #(.PIX_W(W)) u0 (.*);

  int     n_chk = 0, n_fail = 0;
  string  tag = "R1";
  logic [W-1:0] e_a = '0, e_b = '0;
  logic   e_oea = 0, e_oeb = 0, e_dclk = 0, e_hs = 0, e_vs = 0, e_sog = 0;
  bit     m_dem = 1, m_par = 1, m_swp = 1, m_hsprev = 0, m_oddnext = 1;
  logic [W-1:0] pend[$];
  logic [W-1:0] m_last = '0;
  int     pcount = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "port_a", 32'(port_a), 32'(e_a));
    chk(tag, "port_b", 32'(port_b), 32'(e_b));
    chk(tag, "oe_a", 32'(oe_a), 32'(e_oea));
    chk(tag, "oe_b", 32'(oe_b), 32'(e_oeb));
    chk(tag, "dclk_en", 32'(dclk_en), 32'(e_dclk));
    chk("R8", "hs_out", 32'(hs_out), 32'(e_hs));
    chk("R8", "sog_out", 32'(sog_out), 32'(e_sog));
    chk("R9", "vs_out", 32'(vs_out), 32'(e_vs));
  endtask

  // One pixel clock: drive, predict, let the edge pass, compare.
  task automatic cyc(bit hs);
    bit lead, odd;
    logic [W-1:0] p, first;
    pcount++;
    p = W'(pcount * 32'h9E37 + 32'h51);
    pix_in = p; hs_in = hs;
    vs_in = pcount[4]; sog_in = pcount[2];
    lead = hs && !m_hsprev;
    m_hsprev = hs;
    if (lead) begin
      m_dem = cfg_demux; m_par = cfg_pair; m_swp = cfg_swap;
      pend.delete();
      odd = 1;
    end else odd = m_oddnext;
    m_oddnext = !odd;
    e_oea = 1; e_oeb = m_dem;
    if (!m_dem) begin
      e_a = p; e_b = '0; e_dclk = 1;
    end else if (!m_par) begin
      if (odd ^ m_swp) e_a = p; else e_b = p;
      e_dclk = 1;
    end else if (odd) begin
      pend.push_back(p); e_dclk = 0;
    end else begin
      first = (pend.size() > 0) ? pend.pop_front() : m_last;
      m_last = first;
      if (m_swp) begin e_a = p; e_b = first; end
      else       begin e_a = first; e_b = p; end
      e_dclk = 1;
    end
    e_hs = hs ^ cfg_hs_neg; e_sog = sog_in ^ cfg_hs_neg; e_vs = vs_in ^ cfg_vs_inv;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic line(int n);
    for (int i = 0; i < n; i++) cyc(i < 3);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: everything low under reset
    compare_all();
    chk("R1", "port_a in reset", 32'(port_a), 0);
    rst_n = 1'b1;
    // R1: controls at 0 but no leading edge yet -> defaults (dual, pair, swap)
    tag = "R1";
    for (int i = 0; i < 6; i++) cyc(0);
    chk("R1", "pair strobe after 6 samples", 32'(dclk_en), 1);
    tag = "R2"; cfg_demux = 0; cfg_pair = 1; cfg_swap = 1;
    line(9);
    tag = "R3"; cfg_demux = 1; cfg_pair = 0; cfg_swap = 0; cfg_hs_neg = 1;
    line(10);
    tag = "R5"; cfg_swap = 1; cfg_vs_inv = 1;
    line(9);
    tag = "R4"; cfg_pair = 1; cfg_swap = 0;
    line(12);
    tag = "R5"; cfg_swap = 1; cfg_hs_neg = 0;
    line(10);
    // R6: odd-length pair lines drop the leftover sample
    tag = "R6"; cfg_swap = 0;
    line(7);
    line(9);
    line(8);
    // R7: controls change mid-line, line stays in pair mode
    tag = "R7";
    for (int i = 0; i < 4; i++) cyc(i < 3);
    cfg_demux = 0; cfg_pair = 0; cfg_vs_inv = 0;
    for (int i = 0; i < 5; i++) begin
      cyc(0);
      chk("R7", "oe_b kept mid-line", 32'(oe_b), 1);
    end
    line(6);
    chk("R7", "oe_b released after edge", 32'(oe_b), 0);
    tag = "R3"; cfg_demux = 1; cfg_hs_neg = 1;
    line(11);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule